// File: doc/BRIEF.md
# UART Register and Interrupt Block

This block is the bus-facing half of a simple byte UART. An APB master programs it through a small register window. Behind that window sit a one-byte transmit holding register, a one-byte receive holding register, a status word, a control word, an interrupt status word, a 20-bit baud divisor and twelve read-only identification bytes. A serial engine, which is not part of this block, takes transmit bytes through a valid/take handshake. It delivers received bytes as single-cycle valid pulses.

The block detects overrun in both directions. On the transmit side this is a write while a byte is still pending. On the receive side it is an arrival while the previous byte is still unread. The block raises four separate interrupt lines and one combined line. The two overrun interrupt bits are not stored. Each is formed live from a status overrun flag and its enable. Clearing one through the interrupt status register therefore clears the underlying status flag.

Top module: `uart_regblk`

## Requirements
- R1: After reset, every register reads zero (state, control, interrupt status, divisor, and both holding bytes through offset 0x000). All five interrupt outputs and `tx_valid` are low.
- R2: The offsets are: data 0x000, state 0x004, control 0x008, interrupt status 0x00C, divisor 0x010.
  - Offsets 0xFD0 to 0xFFC, in steps of 4, read the bytes 0x04, 0x00, 0x00, 0x00, 0x21, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order.
  - Writes to the identification offsets and to undecoded offsets change nothing, and undecoded offsets read zero.
- R3: Control keeps only bits [6:0]:
  - bit0 transmit enable, bit1 receive enable, bit2 transmit interrupt enable, bit3 receive interrupt enable, bit4 transmit-overrun interrupt enable, bit5 receive-overrun interrupt enable, bit6 test.
  - The divisor keeps only bits [19:0].
- R4: A data write while transmit-full (state bit0) is 0 loads the byte and sets transmit-full. `tx_valid` is transmit-full AND transmit enable, and `tx_byte` shows the holding byte.
- R5: A data write while transmit-full is 1 replaces the holding byte and sets transmit overrun (state bit2).
- R6: A `tx_take` while `tx_valid` is high clears transmit-full. If transmit interrupt enable is 1, it sets interrupt status bit0.
- R7: A byte arriving on `rx_valid` while receive enable is 1 is loaded and sets receive-full (state bit1). If receive interrupt enable is 1, it also sets interrupt status bit1. A byte arriving while receive enable is 0 is discarded.
- R8: A byte arriving while receive-full is 1 overwrites the holding byte and sets receive overrun (state bit3).
- R9: A read of offset 0x000 returns the receive holding byte and clears receive-full.
- R10: Writing 1 to state bit2 or bit3 clears that flag. State bits 0 and 1 ignore writes.
- R11: Interrupt status bits 3:2 always equal state bits 3:2 ANDed with control bits 5:4.
  - Writing 1 to bit2 or bit3 clears the matching state overrun flag.
  - Writing 1 to bit0 or bit1 clears that stored bit.
- R12: `irq_tx`, `irq_rx`, `irq_txovr` and `irq_rxovr` follow interrupt status bits 0 to 3. `irq_any` is their OR.
- R13: `pready` is always 1 and `pslverr` always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tx_byte | output | BYTE_W | Transmit holding byte |
| tx_valid | output | 1 | Byte pending and transmit enabled |
| tx_take | input | 1 | Engine consumes the pending byte |
| rx_byte | input | BYTE_W | Received byte |
| rx_valid | input | 1 | One-cycle pulse with a received byte |
| baud_div | output | DIV_W | Programmed divisor for the engine |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit overrun interrupt |
| irq_rxovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of all interrupt status bits |

## Verification
The holding registers are tried in four patterns, and each pattern tells a different case apart:
- A single write with transmit disabled separates the full flag from the valid output.
- A second write while the first byte is pending separates replacement with overrun from a plain load.
- Two back-to-back arrivals separate an overwrite with overrun from a first load.
- An arrival with receive disabled must leave the previously read byte in place.

Overrun flags are cleared once through the state register and once through the interrupt status register, with the enable both off and on, to show that the overrun interrupt is live rather than stored.

// File: rtl/uart_regblk_pkg.sv
package uart_regblk_pkg;

   localparam int CTRL_W = 7;

   // control bit positions
   localparam int CB_TX_EN  = 0;
   localparam int CB_RX_EN  = 1;
   localparam int CB_TX_IE  = 2;
   localparam int CB_RX_IE  = 3;
   localparam int CB_TXO_IE = 4;
   localparam int CB_RXO_IE = 5;

   // state / interrupt status bit positions
   localparam int SB_TX   = 0;
   localparam int SB_RX   = 1;
   localparam int SB_TXO  = 2;
   localparam int SB_RXO  = 3;
   localparam int STAT_W  = 4;

   localparam int ID_COUNT = 12;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_STATE,
      SEL_CTRL,
      SEL_ISR,
      SEL_DIV,
      SEL_ID
   } reg_sel_e;

   function automatic logic [7:0] id_byte(input logic [3:0] idx);
      logic [7:0] b;
      case (idx)
         4'd0:    b = 8'h04;
         4'd4:    b = 8'h21;
         4'd5:    b = 8'hB8;
         4'd6:    b = 8'h1B;
         4'd8:    b = 8'h0D;
         4'd9:    b = 8'hF0;
         4'd10:   b = 8'h05;
         4'd11:   b = 8'hB1;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
   import uart_regblk_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter bit ID_EN  = 1'b1
)(
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic [7:0]        id_data
);

   localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(32'h000);
   localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(32'h004);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(32'h008);
   localparam logic [ADDR_W-1:0] A_ISR   = ADDR_W'(32'h00C);
   localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(32'h010);
   localparam logic [ADDR_W-1:0] A_IDLO  = ADDR_W'(32'hFD0);
   localparam logic [ADDR_W-1:0] A_IDHI  = ADDR_W'(32'hFFC);

   logic             id_hit;
   logic [ADDR_W-1:0] id_off;

   assign id_off = addr - A_IDLO;

   generate
      if (ID_EN) begin : g_id
         assign id_hit  = (addr >= A_IDLO) && (addr <= A_IDHI) && (addr[1:0] == 2'b00);
         assign id_data = id_hit ? id_byte(id_off[5:2]) : 8'h00;
      end else begin : g_no_id
         assign id_hit  = 1'b0;
         assign id_data = 8'h00;
      end
   endgenerate

   always_comb begin
      if      (addr == A_DATA)  sel = SEL_DATA;
      else if (addr == A_STATE) sel = SEL_STATE;
      else if (addr == A_CTRL)  sel = SEL_CTRL;
      else if (addr == A_ISR)   sel = SEL_ISR;
      else if (addr == A_DIV)   sel = SEL_DIV;
      else if (id_hit)          sel = SEL_ID;
      else                      sel = SEL_NONE;
   end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int BYTE_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              tx_en,
   input  logic              take,
   input  logic              ovr_clr,
   output logic [BYTE_W-1:0] hold,
   output logic              full,
   output logic              ovr,
   output logic              valid,
   output logic              drained
);

   logic take_ok;

   assign valid   = full & tx_en;
   assign take_ok = valid & take;
   // a write in the same cycle as a take refills the slot, so full never drops
   assign drained = take_ok & ~wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= '0;
         full <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (wr_en) hold <= wr_byte;
         if (wr_en)        full <= 1'b1;
         else if (take_ok) full <= 1'b0;
         // setting wins over a clear in the same cycle
         ovr <= (ovr & ~ovr_clr) | (wr_en & full & ~take_ok);
      end
   end

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int BYTE_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              rx_en,
   input  logic              rd_en,
   input  logic              ovr_clr,
   output logic [BYTE_W-1:0] hold,
   output logic              full,
   output logic              ovr,
   output logic              loaded
);

   assign loaded = in_valid & rx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= '0;
         full <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (loaded) hold <= in_byte;
         if (loaded)     full <= 1'b1;
         else if (rd_en) full <= 1'b0;
         ovr <= (ovr & ~ovr_clr) | (loaded & full);
      end
   end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
   import uart_regblk_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ev_set,
   input  logic [1:0]        ev_ie,
   input  logic [1:0]        ev_clr,
   input  logic [1:0]        ovr_flag,
   input  logic [1:0]        ovr_ie,
   output logic [STAT_W-1:0] isr,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic              irq_txovr,
   output logic              irq_rxovr,
   output logic              irq_any
);

   logic [1:0] ev_q;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_ev
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ev_q[g] <= 1'b0;
            else        ev_q[g] <= (ev_q[g] & ~ev_clr[g]) | (ev_set[g] & ev_ie[g]);
         end
      end
   endgenerate

   assign isr       = {ovr_flag & ovr_ie, ev_q};
   assign irq_tx    = isr[SB_TX];
   assign irq_rx    = isr[SB_RX];
   assign irq_txovr = isr[SB_TXO];
   assign irq_rxovr = isr[SB_RXO];
   assign irq_any   = |isr;

endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
   import uart_regblk_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int DIV_W  = 20,
   parameter bit ID_EN  = 1'b1
)(
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              tx_valid,
   input  logic              tx_take,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_valid,
   output logic [DIV_W-1:0]  baud_div,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic              irq_txovr,
   output logic              irq_rxovr,
   output logic              irq_any
);

   generate
      if (ADDR_W < 12) begin : g_chk_addr
         $error("ADDR_W must cover the identification window");
      end
      if (DATA_W < DIV_W || DATA_W < BYTE_W || DATA_W < 8) begin : g_chk_data
         $error("DATA_W too narrow for the registers");
      end
   endgenerate

   reg_sel_e          sel;
   logic [7:0]        id_data;
   logic              acc, wr, rd;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DIV_W-1:0]  div_q;
   logic [1:0]        ovr_clr;
   logic [1:0]        ev_clr;
   logic [BYTE_W-1:0] rx_hold;
   logic              tx_full, tx_ovr, tx_drained;
   logic              rx_full, rx_ovr, rx_loaded;
   logic [STAT_W-1:0] isr;
   logic [STAT_W-1:0] state_w;

   assign acc     = psel & penable;
   assign wr      = acc & pwrite;
   assign rd      = acc & ~pwrite;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   uart_addr_dec #(.ADDR_W(ADDR_W), .ID_EN(ID_EN)) u_dec (
      .addr    (paddr),
      .sel     (sel),
      .id_data (id_data)
   );

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         ctrl_q <= '0;
         div_q  <= '0;
      end else begin
         if (wr && sel == SEL_CTRL) ctrl_q <= pwdata[CTRL_W-1:0];
         if (wr && sel == SEL_DIV)  div_q  <= pwdata[DIV_W-1:0];
      end
   end

   assign baud_div = div_q;

   // overrun flags clear from either the state or the interrupt status offset
   assign ovr_clr = (wr && (sel == SEL_STATE || sel == SEL_ISR)) ? pwdata[SB_RXO:SB_TXO] : 2'b00;
   assign ev_clr  = (wr && sel == SEL_ISR) ? pwdata[SB_RX:SB_TX] : 2'b00;

   uart_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
      .clk     (pclk),
      .rst_n   (presetn),
      .wr_en   (wr && sel == SEL_DATA),
      .wr_byte (pwdata[BYTE_W-1:0]),
      .tx_en   (ctrl_q[CB_TX_EN]),
      .take    (tx_take),
      .ovr_clr (ovr_clr[0]),
      .hold    (tx_byte),
      .full    (tx_full),
      .ovr     (tx_ovr),
      .valid   (tx_valid),
      .drained (tx_drained)
   );

   uart_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
      .clk      (pclk),
      .rst_n    (presetn),
      .in_valid (rx_valid),
      .in_byte  (rx_byte),
      .rx_en    (ctrl_q[CB_RX_EN]),
      .rd_en    (rd && sel == SEL_DATA),
      .ovr_clr  (ovr_clr[1]),
      .hold     (rx_hold),
      .full     (rx_full),
      .ovr      (rx_ovr),
      .loaded   (rx_loaded)
   );

   uart_irq_unit u_irq (
      .clk       (pclk),
      .rst_n     (presetn),
      .ev_set    ({rx_loaded, tx_drained}),
      .ev_ie     ({ctrl_q[CB_RX_IE], ctrl_q[CB_TX_IE]}),
      .ev_clr    (ev_clr),
      .ovr_flag  ({rx_ovr, tx_ovr}),
      .ovr_ie    ({ctrl_q[CB_RXO_IE], ctrl_q[CB_TXO_IE]}),
      .isr       (isr),
      .irq_tx    (irq_tx),
      .irq_rx    (irq_rx),
      .irq_txovr (irq_txovr),
      .irq_rxovr (irq_rxovr),
      .irq_any   (irq_any)
   );

   assign state_w = {rx_ovr, tx_ovr, rx_full, tx_full};

   always_comb begin
      prdata = '0;
      case (sel)
         SEL_DATA:  prdata[BYTE_W-1:0] = rx_hold;
         SEL_STATE: prdata[STAT_W-1:0] = state_w;
         SEL_CTRL:  prdata[CTRL_W-1:0] = ctrl_q;
         SEL_ISR:   prdata[STAT_W-1:0] = isr;
         SEL_DIV:   prdata[DIV_W-1:0]  = div_q;
         SEL_ID:    prdata[7:0]        = id_data;
         default:   prdata             = '0;
      endcase
   end

endmodule

// File: rtl/uart_regblk_chk.sv
module uart_regblk_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int DIV_W  = 20,
   parameter int CTRL_W = 7
)(
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [DATA_W-1:0] pwdata,
   input logic              tx_take,
   input logic              rx_valid,
   input logic              tx_full,
   input logic              tx_ovr,
   input logic              rx_full,
   input logic              rx_ovr,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [DIV_W-1:0]  baud_div,
   input logic              irq_tx
);

   logic acc_w, acc_r;
   assign acc_w = psel & penable & pwrite;
   assign acc_r = psel & penable & ~pwrite;

   logic is_data, is_state, is_ctrl, is_isr, is_div;
   assign is_data  = paddr == ADDR_W'(32'h000);
   assign is_state = paddr == ADDR_W'(32'h004);
   assign is_ctrl  = paddr == ADDR_W'(32'h008);
   assign is_isr   = paddr == ADDR_W'(32'h00C);
   assign is_div   = paddr == ADDR_W'(32'h010);

   // R5: a write into a still-pending transmit slot flags overrun
   assert_txovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_w && is_data && tx_full && !(tx_take && ctrl_q[0]) |=> tx_ovr);

   // R8: an accepted arrival onto an unread byte flags overrun
   assert_rxovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && ctrl_q[1] && rx_full |=> rx_ovr);

   // R6: the transmit slot emptying with its enable set raises the transmit interrupt
   assert_txirq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_full) && $past(ctrl_q[2]) |-> irq_tx);

   // R9: reading data with no arrival empties the receive slot
   assert_rxread_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_r && is_data && !(rx_valid && ctrl_q[1]) |=> !rx_full);

   // R3: control and divisor keep the written low bits
   assert_ctrl_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_w && is_ctrl |=> ctrl_q == $past(pwdata[CTRL_W-1:0]));

   assert_div_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_w && is_div |=> baud_div == $past(pwdata[DIV_W-1:0]));

   // R10: an overrun flag persists until a clearing write
   assert_txovr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ovr && !(acc_w && (is_state || is_isr) && pwdata[2]) |=> tx_ovr);

   assert_rxovr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr && !(acc_w && (is_state || is_isr) && pwdata[3]) |=> rx_ovr);

endmodule

bind uart_regblk uart_regblk_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .DIV_W  (DIV_W),
   .CTRL_W (7)
) u_chk (
   .clk      (pclk),
   .rst_n    (presetn),
   .psel     (psel),
   .penable  (penable),
   .pwrite   (pwrite),
   .paddr    (paddr),
   .pwdata   (pwdata),
   .tx_take  (tx_take),
   .rx_valid (rx_valid),
   .tx_full  (tx_full),
   .tx_ovr   (tx_ovr),
   .rx_full  (rx_full),
   .rx_ovr   (rx_ovr),
   .ctrl_q   (ctrl_q),
   .baud_div (baud_div),
   .irq_tx   (irq_tx)
);

// File: tb/uart_regblk_bench.sv
module uart_regblk_bench;

   localparam int CLK_HALF = 2;   // 250 MHz

   localparam logic [2:0] OP_WR   = 3'd0;
   localparam logic [2:0] OP_RD   = 3'd1;
   localparam logic [2:0] OP_RXB  = 3'd2;
   localparam logic [2:0] OP_TAKE = 3'd3;
   localparam logic [2:0] OP_IRQ  = 3'd4;
   localparam logic [2:0] OP_TXC  = 3'd5;

   typedef struct packed {
      logic [2:0]  op;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] expv;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 59;

   // irq compare vector: {irq_any, irq_rxovr, irq_txovr, irq_rx, irq_tx}
   // tx compare vector : {tx_valid, tx_byte}
   localparam vec_t VECS [0:NV-1] = '{
      '{OP_RD,   12'h004, 32'h0,        32'h0,     4'd1},  // R1
      '{OP_RD,   12'h008, 32'h0,        32'h0,     4'd1},  // R1
      '{OP_RD,   12'h00C, 32'h0,        32'h0,     4'd1},  // R1
      '{OP_RD,   12'h010, 32'h0,        32'h0,     4'd1},  // R1
      '{OP_RD,   12'h000, 32'h0,        32'h0,     4'd1},  // R1
      '{OP_RD,   12'hFD0, 32'h0,        32'h04,    4'd2},  // R2
      '{OP_RD,   12'hFE4, 32'h0,        32'hB8,    4'd2},  // R2
      '{OP_RD,   12'hFF0, 32'h0,        32'h0D,    4'd2},  // R2
      '{OP_RD,   12'hFFC, 32'h0,        32'hB1,    4'd2},  // R2
      '{OP_RD,   12'h014, 32'h0,        32'h0,     4'd2},  // R2
      '{OP_WR,   12'h008, 32'hFFFFFFFF, 32'h0,     4'd3},
      '{OP_RD,   12'h008, 32'h0,        32'h7F,    4'd3},  // R3
      '{OP_WR,   12'h010, 32'hFFFFFFFF, 32'h0,     4'd3},
      '{OP_RD,   12'h010, 32'h0,        32'hFFFFF, 4'd3},  // R3
      '{OP_WR,   12'h008, 32'h0,        32'h0,     4'd4},
      '{OP_WR,   12'h000, 32'h5A,       32'h0,     4'd4},
      '{OP_RD,   12'h004, 32'h0,        32'h1,     4'd4},  // R4
      '{OP_TXC,  12'h000, 32'h0,        32'h05A,   4'd4},  // R4 disabled: no valid
      '{OP_WR,   12'h008, 32'h05,       32'h0,     4'd4},
      '{OP_TXC,  12'h000, 32'h0,        32'h15A,   4'd4},  // R4
      '{OP_WR,   12'h000, 32'hA5,       32'h0,     4'd5},
      '{OP_RD,   12'h004, 32'h0,        32'h5,     4'd5},  // R5
      '{OP_TXC,  12'h000, 32'h0,        32'h1A5,   4'd5},  // R5
      '{OP_IRQ,  12'h000, 32'h0,        32'h00,    4'd11}, // R11 enable off
      '{OP_WR,   12'h008, 32'h15,       32'h0,     4'd11},
      '{OP_IRQ,  12'h000, 32'h0,        32'h14,    4'd12}, // R12
      '{OP_RD,   12'h00C, 32'h0,        32'h4,     4'd11}, // R11
      '{OP_WR,   12'h00C, 32'h4,        32'h0,     4'd11},
      '{OP_RD,   12'h004, 32'h0,        32'h1,     4'd11}, // R11
      '{OP_TAKE, 12'h000, 32'h0,        32'h0,     4'd6},
      '{OP_IRQ,  12'h000, 32'h0,        32'h11,    4'd6},  // R6
      '{OP_RD,   12'h004, 32'h0,        32'h0,     4'd6},  // R6
      '{OP_RD,   12'h00C, 32'h0,        32'h1,     4'd6},  // R6
      '{OP_WR,   12'h00C, 32'h1,        32'h0,     4'd11},
      '{OP_RD,   12'h00C, 32'h0,        32'h0,     4'd11}, // R11
      '{OP_WR,   12'h008, 32'h2A,       32'h0,     4'd7},
      '{OP_RXB,  12'h000, 32'h33,       32'h0,     4'd7},
      '{OP_RD,   12'h004, 32'h0,        32'h2,     4'd7},  // R7
      '{OP_IRQ,  12'h000, 32'h0,        32'h12,    4'd7},  // R7
      '{OP_RXB,  12'h000, 32'h44,       32'h0,     4'd8},
      '{OP_RD,   12'h004, 32'h0,        32'hA,     4'd8},  // R8
      '{OP_IRQ,  12'h000, 32'h0,        32'h1A,    4'd12}, // R12
      '{OP_RD,   12'h000, 32'h0,        32'h44,    4'd9},  // R9
      '{OP_RD,   12'h004, 32'h0,        32'h8,     4'd9},  // R9
      '{OP_WR,   12'h004, 32'hB,        32'h0,     4'd10},
      '{OP_RD,   12'h004, 32'h0,        32'h0,     4'd10}, // R10
      '{OP_RD,   12'h00C, 32'h0,        32'h2,     4'd10}, // R10
      '{OP_WR,   12'h00C, 32'h2,        32'h0,     4'd11},
      '{OP_IRQ,  12'h000, 32'h0,        32'h00,    4'd11}, // R11
      '{OP_WR,   12'h008, 32'h0,        32'h0,     4'd7},
      '{OP_RXB,  12'h000, 32'h77,       32'h0,     4'd7},
      '{OP_RD,   12'h004, 32'h0,        32'h0,     4'd7},  // R7 discarded
      '{OP_RD,   12'h000, 32'h0,        32'h44,    4'd7},  // R7 byte kept
      '{OP_WR,   12'hFD0, 32'hFF,       32'h0,     4'd2},
      '{OP_RD,   12'hFD0, 32'h0,        32'h04,    4'd2},  // R2
      '{OP_WR,   12'h020, 32'hFFFFFFFF, 32'h0,     4'd2},
      '{OP_RD,   12'h008, 32'h0,        32'h0,     4'd2},  // R2
      '{OP_RD,   12'h010, 32'h0,        32'hFFFFF, 4'd3},  // R3
      '{OP_TXC,  12'h000, 32'h0,        32'h0A5,   4'd4}   // R4
   };

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [7:0]  tx_byte;
   logic        tx_valid;
   logic        tx_take = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_valid = 1'b0;
   logic [19:0] baud_div;
   logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_HALF) pclk = ~pclk;

   uart_regblk u_uart_regblk (
      .pclk      (pclk),
      .presetn   (presetn),
      .psel      (psel),
      .penable   (penable),
      .pwrite    (pwrite),
      .paddr     (paddr),
      .pwdata    (pwdata),
      .prdata    (prdata),
      .pready    (pready),
      .pslverr   (pslverr),
      .tx_byte   (tx_byte),
      .tx_valid  (tx_valid),
      .tx_take   (tx_take),
      .rx_byte   (rx_byte),
      .rx_valid  (rx_valid),
      .baud_div  (baud_div),
      .irq_tx    (irq_tx),
      .irq_rx    (irq_rx),
      .irq_txovr (irq_txovr),
      .irq_rxovr (irq_rxovr),
      .irq_any   (irq_any)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      d = prdata;
      // R13: response lines fixed during every access
      check("R13 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   function automatic logic [31:0] irq_vec();
      return {27'b0, irq_any, irq_rxovr, irq_txovr, irq_rx, irq_tx};
   endfunction

   initial begin
      #(2 * CLK_HALF * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      repeat (3) @(negedge pclk);
      // R1: reset-state outputs
      check("R1 irq at reset", irq_vec(), 32'h0);
      check("R1 tx_valid at reset", {31'b0, tx_valid}, 32'h0);
      presetn = 1'b1;
      @(negedge pclk);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string tag;
         v = VECS[i];
         tag = $sformatf("R%0d vec%0d", v.req, i);
         case (v.op)
            OP_WR: apb_wr(v.addr, v.data);
            OP_RD: begin
               apb_rd(v.addr, rv);
               check(tag, rv, v.expv);
            end
            OP_RXB: begin
               @(negedge pclk);
               rx_byte = v.data[7:0]; rx_valid = 1'b1;
               @(negedge pclk);
               rx_valid = 1'b0;
            end
            OP_TAKE: begin
               @(negedge pclk);
               tx_take = 1'b1;
               @(negedge pclk);
               tx_take = 1'b0;
            end
            OP_IRQ: begin
               @(negedge pclk);
               check(tag, irq_vec(), v.expv);
            end
            default: begin
               @(negedge pclk);
               check(tag, {23'b0, tx_valid, tx_byte}, v.expv);
            end
         endcase
      end

      // R1: reset in mid-run returns programmed registers to zero
      apb_wr(12'h008, 32'h7F);
      @(negedge pclk);
      presetn = 1'b0;
      @(negedge pclk);
      presetn = 1'b1;
      apb_rd(12'h008, rv);
      check("R1 ctrl after reset", rv, 32'h0);
      apb_rd(12'h010, rv);
      check("R1 divisor after reset", rv, 32'h0);
      check("R1 divisor port after reset", {12'b0, baud_div}, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule